// File: doc/BRIEF.md
# Tone Digit Capture and Playback Controller

This block sits behind an external tone-decoder front end. Each time the decoder reports a new keypad digit, the block stores it in an on-chip memory. The decoder supplies the digit as a 4-bit code and raises a data-valid level while the digit is present. Later, a user steps through the stored sequence one digit at a time with a push-button. The current digit drives a binary LED display or a seven-segment decoder, and the current address is also brought out.

A single address pointer serves both modes. In record mode, a rising data-valid level writes the code at the pointer and then moves the pointer to the next location. In playback mode, writes are blocked and each debounced press of the advance button moves the pointer forward by one. A clear button returns the pointer to zero in either mode, so recording and playback both start from the first location. The data-valid, clear, advance and mode inputs each pass through a two-flip-flop synchroniser. The digit code is sampled directly, because the decoder holds it steady while data-valid is high.

Top module: `digit_recorder`

## Requirements
- R1: The digit code is 4 bits wide with bit weights 8, 4, 2, 1 (bit 3 has weight 8). `digitOut` presents a stored code unchanged, so a stored 15 reads back with all four bits set.
- R2: In record mode (`modeRead`=0), a low-to-high change of `dataValid` stores `digitIn` at the current address.
- R3: One clock cycle after each write, the address increases by one, so the next digit goes to the following location.
- R4: Only one write and one address step happen per `dataValid` pulse, however long the pulse stays high.
- R5: While `clearBtn` is high (after synchronisation), the address is 0, in either mode. `rstN` low also forces the address to 0. Stored contents are not erased.
- R6: In playback mode (`modeRead`=1), each accepted press of `stepBtn` advances the address by one. `digitOut` continuously shows the memory word at the current address.
- R7: In playback mode, `dataValid` edges are ignored: no memory word changes and the address holds.
- R8: In record mode, presses of `stepBtn` are ignored and the address holds.
- R9: A press is accepted only after the synchronised `stepBtn` level has held high for `DEBOUNCE_CYCLES` consecutive clocks. Shorter highs and bounces produce no step. A bouncing press that then settles high gives exactly one step.
- R10: The address wraps from `DEPTH`-1 to 0, both when recording and when stepping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| digitIn | input | 4 | Digit code from the tone decoder, weights 8-4-2-1 |
| dataValid | input | 1 | Decoder data-valid level; its rising edge marks a new digit |
| modeRead | input | 1 | 0 = record, 1 = playback |
| clearBtn | input | 1 | Clear push-button, active high; returns the address to 0 |
| stepBtn | input | 1 | Advance push-button, active high, raw (bouncing) |
| digitOut | output | 4 | Memory word at the current address |
| addrOut | output | ADDR_W | Current address pointer |

## Verification
The bench builds the block with `DEPTH`=16 and `DEBOUNCE_CYCLES`=8, in place of 2048 and ten milliseconds of clock. With a 16-word memory, the bench can record enough digits to wrap the address back to 0 and then read the first of those words at the wrapped address. The eight-cycle filter lets the bench try, in a few hundred clocks each, a clean press, a too-short glitch, and a bouncing press that settles high.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // store digit at current address
    logic advance;  // move pointer forward
    logic clear;    // force pointer to zero
  } ctrlStrobes_t;
endpackage

// File: rtl/tdc_sync.sv
module tdc_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/tdc_debounce.sv
module tdc_debounce #(
  parameter int STABLE_CYCLES = 1250000,
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic levelIn,
  output logic pressPulse
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STABLE_CYCLES - 1);
  logic [CNT_W-1:0] stableCnt;
  logic acceptedLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stableCnt   <= '0;
      acceptedLvl <= 1'b0;
      pressPulse  <= 1'b0;
    end else begin
      pressPulse <= 1'b0;
      if (levelIn == acceptedLvl) begin
        stableCnt <= '0;
      end else if (stableCnt == LIMIT) begin
        stableCnt   <= '0;
        acceptedLvl <= levelIn;
        pressPulse  <= levelIn;
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdc_control.sv
module tdc_control
  import tdc_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 1250000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         dataValid,
  input  logic         modeRead,
  input  logic         clearBtn,
  input  logic         stepBtn,
  output ctrlStrobes_t strobes
);
  logic [3:0] syncd;
  logic dvS, modeS, clearS, stepS;
  logic dvPrev, incPending, stepPulse, dvRise;

  tdc_sync #(.WIDTH(4)) i_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({dataValid, modeRead, clearBtn, stepBtn}),
    .syncOut(syncd)
  );
  assign {dvS, modeS, clearS, stepS} = syncd;

  tdc_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) i_deb (
    .clk(clk), .rstN(rstN), .levelIn(stepS), .pressPulse(stepPulse)
  );

  assign dvRise = dvS & ~dvPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dvPrev     <= 1'b0;
      incPending <= 1'b0;
    end else begin
      dvPrev     <= dvS;
      incPending <= dvRise & ~modeS;
    end
  end

  always_comb begin
    strobes.wrEn    = dvRise & ~modeS;
    strobes.advance = incPending | (stepPulse & modeS);
    strobes.clear   = clearS;
  end
endmodule

// File: rtl/tdc_datapath.sv
module tdc_datapath
  import tdc_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int DEPTH   = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [DIGIT_W-1:0] digitIn,
  output logic [DIGIT_W-1:0] digitOut,
  output logic [ADDR_W-1:0]  addrOut
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
  logic [DIGIT_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0]  addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                addrQ <= '0;
    else if (strobes.clear)   addrQ <= '0;
    else if (strobes.advance) addrQ <= (addrQ == LAST) ? '0 : addrQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobes.wrEn) mem[addrQ] <= digitIn;
  end

  assign digitOut = mem[addrQ];
  assign addrOut  = addrQ;
endmodule

// File: rtl/digit_recorder.sv
module digit_recorder
  import tdc_pkg::*;
#(
  parameter int DIGIT_W         = 4,
  parameter int DEPTH           = 2048,
  parameter int DEBOUNCE_CYCLES = 1250000,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DIGIT_W-1:0] digitIn,
  input  logic               dataValid,
  input  logic               modeRead,
  input  logic               clearBtn,
  input  logic               stepBtn,
  output logic [DIGIT_W-1:0] digitOut,
  output logic [ADDR_W-1:0]  addrOut
);
  ctrlStrobes_t strobes;

  tdc_control #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .dataValid(dataValid), .modeRead(modeRead),
    .clearBtn(clearBtn), .stepBtn(stepBtn), .strobes(strobes)
  );

  tdc_datapath #(.DIGIT_W(DIGIT_W), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .digitIn(digitIn),
    .digitOut(digitOut), .addrOut(addrOut)
  );
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
  parameter int DEPTH = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrOut,
  input logic              wrEn,
  input logic              advance,
  input logic              clear
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (addrOut == '0));

  p_step_wrap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !clear) |=>
      (addrOut == (($past(addrOut) == LAST) ? '0 : $past(addrOut) + 1'b1)));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !clear) |=> $stable(addrOut));

  p_single_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  p_step_after_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> advance);
endmodule

bind digit_recorder tdc_checker #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rstN(rstN), .addrOut(addrOut),
  .wrEn(strobes.wrEn), .advance(strobes.advance), .clear(strobes.clear)
);

// File: tb/test_digit_recorder.sv
`timescale 1ns/1ps
module test_digit_recorder;
  localparam int DEPTH = 16;
  localparam int DEB   = 8;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] digitIn = '0;
  logic dataValid = 1'b0, modeRead = 1'b0, clearBtn = 1'b0, stepBtn = 1'b0;
  logic [3:0] digitOut;
  logic [AW-1:0] addrOut;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  digit_recorder #(.DIGIT_W(4), .DEPTH(DEPTH), .DEBOUNCE_CYCLES(DEB)) i_digit_recorder (
    .clk(clk), .rstN(rstN), .digitIn(digitIn), .dataValid(dataValid),
    .modeRead(modeRead), .clearBtn(clearBtn), .stepBtn(stepBtn),
    .digitOut(digitOut), .addrOut(addrOut)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseDv(logic [3:0] d, int hold);
    digitIn = d; dataValid = 1'b1; cyc(hold);
    dataValid = 1'b0; cyc(8);
  endtask

  task automatic press(int high);
    stepBtn = 1'b1; cyc(high);
    stepBtn = 1'b0; cyc(DEB + 10);
  endtask

  task automatic doClear();
    clearBtn = 1'b1; cyc(5);
    clearBtn = 1'b0; cyc(5);
  endtask

  task automatic setMode(logic m);
    modeRead = m; cyc(5);
  endtask

  task automatic t_reset();
    chk("R5 reset address", int'(addrOut), 0);
  endtask

  task automatic t_record();
    pulseDv(4'd3, 3);  chk("R2/R3 addr after first write", int'(addrOut), 1);
    pulseDv(4'd9, 20); chk("R4 long pulse single step", int'(addrOut), 2);
    pulseDv(4'd0, 3);  chk("R3 addr after third write", int'(addrOut), 3);
    pulseDv(4'd15, 3); chk("R3 addr after fourth write", int'(addrOut), 4);
  endtask

  task automatic t_step_in_record();
    press(DEB + 10);
    chk("R8 step ignored in record mode", int'(addrOut), 4);
    doClear();
    chk("R5 clear in record mode", int'(addrOut), 0);
  endtask

  task automatic t_playback();
    setMode(1'b1);
    doClear();
    chk("R5 clear in playback", int'(addrOut), 0);
    chk("R2/R6 playback word 0", int'(digitOut), 3);
    pulseDv(4'd7, 3);
    chk("R7 dv ignored addr", int'(addrOut), 0);
    chk("R7 dv ignored data", int'(digitOut), 3);
    press(DEB + 10);
    chk("R6 step addr", int'(addrOut), 1);
    chk("R4/R6 word 1", int'(digitOut), 9);
    for (int i = 0; i < 3; i++) begin
      stepBtn = 1'b1; cyc(2); stepBtn = 1'b0; cyc(2);
    end
    press(DEB + 10);
    chk("R9 bouncing press one step", int'(addrOut), 2);
    chk("R6 word 2", int'(digitOut), 0);
    press(DEB - 4);
    chk("R9 short glitch no step", int'(addrOut), 2);
    press(DEB + 10);
    chk("R6 step addr 3", int'(addrOut), 3);
    chk("R1 code 15 all bits", int'(digitOut[3]) * 8 + int'(digitOut[2]) * 4 + int'(digitOut[1]) * 2 + int'(digitOut[0]), 15);
  endtask

  task automatic t_wrap();
    setMode(1'b0);
    doClear();
    for (int i = 0; i < DEPTH; i++) pulseDv(4'(i + 5), 3);
    chk("R10 record wrap addr", int'(addrOut), 0);
    setMode(1'b1);
    chk("R10 word at wrapped addr", int'(digitOut), 5);
    doClear();
    for (int i = 0; i < DEPTH - 1; i++) press(DEB + 2);
    chk("R10 last addr", int'(addrOut), DEPTH - 1);
    chk("R6 last word", int'(digitOut), (DEPTH - 1 + 5) % 16);
    press(DEB + 2);
    chk("R10 step wrap addr", int'(addrOut), 0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rstN = 1'b1;
    cyc(3);
    t_record();
    t_step_in_record();
    t_playback();
    t_wrap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule